// File: doc/BRIEF.md
# Tuner Event Interrupt Pulse Generator

This block drives the general-purpose output pin of a radio tuner. A two-bit mode input decides what the pin does. It can float, it can be held low or held high as a plain output, or it can act as an interrupt line. As an interrupt line it sends out active-low pulses of a fixed width. The pulse width is counted on an external millisecond tick.

Two event sources can raise a pulse: completion of a seek or tune operation, and new data becoming available. Each source has its own enable input. Completion has priority within a seek or tune. Once a seek or tune has started and the completion interrupt is enabled, data-ready events are held back until the completion pulse has gone out. An event that arrives while a pulse is still running is not lost. It is latched and pulsed later, after the line has been idle high for at least one tick. Leaving interrupt mode drops any pulse in progress and forgets all pending events.

Top module: `tuner_irq_pin`

## Requirements
- R1: With `mode` = 2'b00 the pin is released: `pin_oe` is 0.
- R2: With `mode` = 2'b10 the pin is driven low, and with `mode` = 2'b11 it is driven high; `pin_oe` is 1 in both cases.
- R3: With `mode` = 2'b01 (interrupt) and nothing pending, `pin_oe` is 1 and `pin_out` is 1.
- R4: A `seek_done` strobe with `done_irq_en` set, taken while the line is idle, drives `pin_out` low from the second rising edge after the strobe. The line stays low for exactly `PULSE_TICKS` tick strobes (5 by default).
- R5: A `data_ready` strobe with `data_irq_en` set produces the same kind of pulse, with the same timing as R4.
- R6: An event whose enable is clear produces no pulse.
- R7: After a `seek_start` strobe, while `done_irq_en` is set, data-ready events produce no pulse until the completion pulse has been issued. When `seek_done` then arrives, the completion pulse comes first, and the held data pulse follows it.
- R8: An event arriving during a pulse is latched. Its pulse starts only after the line has been high for at least `GAP_TICKS` tick strobes (1 by default).
- R9: Changing `mode` away from 2'b01 ends a pulse in progress at once and clears all pending events. After a return to 2'b01, no pulse appears for those events.
- R10: Events that occur while `mode` is not 2'b01 are not recorded and produce no pulse later.
- R11: With `done_irq_en` clear, a `seek_start` does not hold back data-ready pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe every millisecond; times the pulse and the gap |
| mode | input | 2 | Pin behaviour: 00 float, 01 interrupt, 10 low, 11 high |
| done_irq_en | input | 1 | Enables the seek/tune completion interrupt |
| data_irq_en | input | 1 | Enables the data-ready interrupt |
| seek_start | input | 1 | Strobe: a seek or tune has begun |
| seek_done | input | 1 | Strobe: a seek or tune has finished |
| data_ready | input | 1 | Strobe: new data is available |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output enable; 0 means high impedance |

## Verification
A stuck or wrong state in the pulse sequencer shows at the pin within one tick period. It appears as a pulse of the wrong width, a missing recovery gap, or a line that never returns high. A lost or phantom pending flag shows as a missing or extra falling edge. The bench counts every falling edge against an expected queue, so such an error is caught on the first edge that does not match. A broken hold flag shows as a data pulse during the window between seek start and seek completion. Pending state that survives a mode change shows as a pulse shortly after interrupt mode is re-entered.

// File: rtl/tuner_irq_pin.sv
module tuner_irq_pin #(
  parameter int PULSE_TICKS = 5,
  parameter int GAP_TICKS   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       done_irq_en,
  input  logic       data_irq_en,
  input  logic       seek_start,
  input  logic       seek_done,
  input  logic       data_ready,
  output logic       pin_out,
  output logic       pin_oe
);
  localparam int MAXT = (PULSE_TICKS > GAP_TICKS) ? PULSE_TICKS : GAP_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [1:0] {IDLE, PULSE, GAP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic done_pend, data_pend, seek_busy;

  wire irq      = (mode == 2'b01);
  wire done_set = irq & seek_done & done_irq_en;
  wire data_set = irq & data_ready & data_irq_en;
  wire hold     = seek_busy & done_irq_en;
  wire go_done  = (st == IDLE) & done_pend;
  wire go_data  = (st == IDLE) & data_pend & ~done_pend & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0;
      done_pend <= 1'b0; data_pend <= 1'b0; seek_busy <= 1'b0;
    end else if (!irq) begin
      st <= IDLE; cnt <= '0;
      done_pend <= 1'b0; data_pend <= 1'b0; seek_busy <= 1'b0;
    end else begin
      done_pend <= done_set | (done_pend & ~go_done);
      data_pend <= data_set | (data_pend & ~go_data);
      if (seek_start) seek_busy <= 1'b1;
      else if (go_done || (seek_done && !done_irq_en)) seek_busy <= 1'b0;
      case (st)
        IDLE: if (go_done || go_data) begin st <= PULSE; cnt <= '0; end
        PULSE: if (tick) begin
          if (cnt == CW'(PULSE_TICKS - 1)) begin st <= GAP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        GAP: if (tick) begin
          if (cnt == CW'(GAP_TICKS - 1)) begin st <= IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (mode)
      2'b00:   pin_out = 1'b1;
      2'b01:   pin_out = (st != PULSE);
      2'b10:   pin_out = 1'b0;
      default: pin_out = 1'b1;
    endcase
  end
  assign pin_oe = (mode != 2'b00);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st == IDLE && !done_pend && !data_pend) |=> pin_out);
  a_r4_width_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st == PULSE && !tick) |=> (st == PULSE || !irq));
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st == IDLE && hold && !done_pend) |=> st != PULSE);
  a_r8_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && st == PULSE && tick && cnt == CW'(PULSE_TICKS - 1)) |=> (pin_out || !irq));
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |=> (st == IDLE && !done_pend && !data_pend && !seek_busy));
endmodule

// File: tb/sim_tuner_irq_pin.sv
module sim_tuner_irq_pin;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 10;
  localparam int PULSE_TICKS = 5;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] mode = 2'b00;
  logic done_irq_en = 0, data_irq_en = 0, seek_start = 0, seek_done = 0, data_ready = 0;
  logic pin_out, pin_oe;

  tuner_irq_pin u0 (.clk, .rst_n, .tick, .mode, .done_irq_en, .data_irq_en,
    .seek_start, .seek_done, .data_ready, .pin_out, .pin_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0, falls = 0;
  int exp_fall_q[$];
  string tag_q[$];
  bit abort_ok = 0;
  bit done_flag = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  bit low = 0, prev_pin = 1, had_pulse = 0;
  int wticks = 0, gticks = 0;
  int cur_fall_exp;
  string cur_tag;
  always @(negedge clk) begin
    if (mode != 2'b01) begin
      if (low) begin
        if (!abort_ok) chk("R9 unexpected abort", 1, 0);
        low = 0;
      end
      prev_pin = 1; had_pulse = 0; gticks = 0;
    end else begin
      if (prev_pin && !pin_out) begin
        falls++;
        if (exp_fall_q.size() == 0) begin
          chk("unexpected pulse", 1, 0);
          cur_tag = "none"; cur_fall_exp = -1;
        end else begin
          cur_fall_exp = exp_fall_q.pop_front();
          cur_tag = tag_q.pop_front();
          if (cur_fall_exp >= 0) chk({cur_tag, " fall cycle"}, cyc, cur_fall_exp);
        end
        if (had_pulse) begin
          checks++;
          if (gticks < 1) begin
            errors++;
            $display("FAIL R8 gap ticks: actual=%0d expected>=1", gticks);
          end
        end
        low = 1; wticks = 0;
      end
      if (low && !pin_out && tick) wticks++;
      if (low && pin_out) begin
        chk({cur_tag, " width ticks"}, wticks, PULSE_TICKS);
        low = 0; had_pulse = 1; gticks = 0;
      end
      if (!low && pin_out && tick) gticks++;
      prev_pin = pin_out;
    end
  end

  task automatic strobe(ref logic s, input string tag, input bit expect_pulse, input bit timed);
    @(negedge clk);
    s = 1;
    if (expect_pulse) begin
      exp_fall_q.push_back(timed ? cyc + 2 : -1);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    s = 0;
  endtask

  task automatic wait_ticks(int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (exp_fall_q.size() != 0 || low) @(negedge clk);
    wait_ticks(3);
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk("R1 oe in float mode", pin_oe, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, 0);
    mode = 2'b10; @(negedge clk);
    chk("R2 low level", pin_out, 0);
    chk("R2 oe low mode", pin_oe, 1);
    mode = 2'b11; @(negedge clk);
    chk("R2 high level", pin_out, 1);
    chk("R2 oe high mode", pin_oe, 1);

    // R10: events outside interrupt mode are dropped
    done_irq_en = 1; data_irq_en = 1;
    strobe(seek_done, "R10", 0, 0);
    strobe(data_ready, "R10", 0, 0);
    mode = 2'b01; @(negedge clk);
    chk("R3 idle level", pin_out, 1);
    chk("R3 oe irq mode", pin_oe, 1);
    f0 = falls; wait_ticks(8);
    chk("R10 no pulse from earlier events", falls, f0);

    // R4 and R5
    data_irq_en = 0;
    strobe(seek_done, "R4", 1, 1); wait_idle();
    done_irq_en = 0; data_irq_en = 1;
    strobe(data_ready, "R5", 1, 1); wait_idle();

    // R6
    data_irq_en = 0; f0 = falls;
    strobe(data_ready, "R6", 0, 0);
    strobe(seek_done, "R6", 0, 0);
    wait_ticks(8);
    chk("R6 disabled events ignored", falls, f0);

    // R7
    done_irq_en = 1; data_irq_en = 1; f0 = falls;
    strobe(seek_start, "R7", 0, 0);
    strobe(data_ready, "R7", 0, 0);
    wait_ticks(10);
    chk("R7 data held during seek", falls, f0);
    strobe(seek_done, "R7 completion first", 1, 1);
    exp_fall_q.push_back(-1); tag_q.push_back("R7 data after completion");
    wait_idle();
    chk("R7 two pulses total", falls, f0 + 2);

    // R11
    done_irq_en = 0; f0 = falls;
    strobe(seek_start, "R11", 0, 0);
    strobe(data_ready, "R11 not held", 1, 1);
    wait_idle();
    strobe(seek_done, "R11", 0, 0);
    wait_ticks(8);
    chk("R11 one pulse only", falls, f0 + 1);

    // R8
    f0 = falls;
    strobe(data_ready, "R8 first", 1, 1);
    repeat (20) @(negedge clk);
    strobe(data_ready, "R8 latched", 1, 0);
    wait_idle();
    chk("R8 both pulses", falls, f0 + 2);

    // R9
    done_irq_en = 1; f0 = falls;
    strobe(data_ready, "R9 cancelled", 1, 1);
    repeat (15) @(negedge clk);
    strobe(seek_done, "R9", 0, 0);
    abort_ok = 1;
    mode = 2'b10; @(negedge clk);
    chk("R9 pin follows new mode", pin_out, 0);
    abort_ok = 0;
    mode = 2'b01; @(negedge clk);
    chk("R9 high on return", pin_out, 1);
    wait_ticks(10);
    chk("R9 pending cleared", falls, f0 + 1);
    chk("R9 queue drained", exp_fall_q.size(), 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule